// File: doc/BRIEF.md
# Three-Level Delay Code Search Controller

This controller converts the up/down decisions of a phase/frequency detector into a 12-bit control word for a digitally controlled delay line. The word has three 4-bit fields of decreasing weight: a cycle-level field, a coarse field and a fine field. The controller searches them one at a time, and always in that order. Each search uses a binary-style adaptive step. The step starts at half scale, so a large initial error shrinks quickly. It then narrows on every change of direction.

The surrounding loop tells the controller when the residual error of the current level has dropped below that level's unit step. The controller then freezes that field and passes control to the next level. The fine level's search starts from the coarse value already found. If the fine field runs off either end, the controller carries into or borrows from the coarse field. Once the fine search keeps reversing at the smallest step, the controller declares lock. After that, only the fine field moves, and only by one.

Top module: `delay_code_search`

## Requirements
- R1: After reset all three fields read 8, the stage output reads 0 (cycle level) and the lock flag is low.
- R2: The stage output takes the values 0 (cycle-level), 1 (coarse) and 2 (fine), in that order and never backwards. While the stage is 0 or 1, a high `belowStep` moves to the next stage at the next edge. That cycle has priority over any request and changes no field. In stage 2 `belowStep` has no effect.
- R3: When only `incReq` is high, the active field (bits [11:8], [7:4] or [3:0] of the control word for stages 0, 1 and 2) grows. When only `decReq` is high, it shrinks. When both or neither are high, no field changes. Outside the carry case of R6, only the active field changes.
- R4: The first move after a stage is entered uses a step of 8. A move in the same direction as the previous move in that stage reuses the current step. A move in the opposite direction halves the step, which never goes below 1.
- R5: In stages 0 and 1, a field that would pass 15 or drop below 0 is held at 15 or 0.
- R6: In stage 2, before lock, a fine move past 15 adds one to the coarse field and sets the fine field to 8. A move below 0 subtracts one from the coarse field and sets the fine field to 8. If the coarse field is already at its limit in that direction, the fine field saturates instead.
- R7: Lock rises when two decisions in a row in stage 2 are each a direction reversal made while the step is already 1. The decision that completes the pair still applies its move. Lock stays high until reset.
- R8: While locked, each decision moves the fine field by exactly 1, saturating at 0 and 15 with no carry or borrow. The cycle-level and coarse fields and the stage do not change.
- R9: All outputs are registered. A request sampled at a rising edge is visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| incReq | input | 1 | Detector says lag / frequency low: increase delay code |
| decReq | input | 1 | Detector says lead / frequency high: decrease delay code |
| belowStep | input | 1 | Residual error is below one step of the active level |
| cycleField | output | 4 | Cycle-level field, control word bits [11:8] |
| coarseField | output | 4 | Coarse field, control word bits [7:4] |
| fineField | output | 4 | Fine field, control word bits [3:0] |
| stage | output | 2 | Active search level: 0 cycle, 1 coarse, 2 fine |
| locked | output | 1 | Search finished and fine tracking active |

## Verification
The step size is hidden state, but a wrong step shows up on the active field at the very next decision. The same holds for a stale direction memory or a step counter that was not restored on a stage change: the field moves by the wrong amount one cycle after the request. A wrong lock count shows as `locked` rising one decision too early or too late. After that, the frozen coarse field also differs from the expected value. Carry errors show in the same cycle on two fields at once, so the bench compares every output after every decision rather than only at the end of a search.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int FIELD_W = 4;
  localparam int NUM_FIELDS = 3;
  localparam logic [FIELD_W-1:0] FIELD_MAX = '1;
  localparam logic [FIELD_W-1:0] FIELD_MID = FIELD_W'(1 << (FIELD_W - 1));

  typedef enum logic [1:0] {
    STG_CYCLE  = 2'd0,
    STG_COARSE = 2'd1,
    STG_FINE   = 2'd2
  } stage_e;

  typedef struct packed {
    logic               moveUp;
    logic               moveDn;
    logic [FIELD_W-1:0] amount;
    stage_e             level;
    logic               carryOk;
  } ctrlStrobe_t;
endpackage

// File: rtl/dcs_ctrl.sv
module dcs_ctrl
  import dcs_pkg::*;
#(
  parameter int LOCK_HITS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        incReq,
  input  logic        decReq,
  input  logic        belowStep,
  output ctrlStrobe_t strobe,
  output stage_e      stage,
  output logic        locked
);
  localparam int HIT_W = $clog2(LOCK_HITS + 1);

  logic               haveDir;
  logic               lastUp;
  logic [FIELD_W-1:0] stepQ;
  logic [HIT_W-1:0]   hits;

  logic               decide;
  logic               advance;
  logic               reversal;
  logic [FIELD_W-1:0] amt;
  logic               tinyRev;

  always_comb begin
    decide   = incReq ^ decReq;
    advance  = belowStep && (stage != STG_FINE);
    reversal = haveDir && (incReq != lastUp);
    tinyRev  = reversal && (stepQ == FIELD_W'(1));
    if (locked)
      amt = FIELD_W'(1);
    else if (reversal)
      amt = (stepQ > FIELD_W'(1)) ? (stepQ >> 1) : FIELD_W'(1);
    else
      amt = stepQ;

    strobe.moveUp  = decide && !advance && incReq;
    strobe.moveDn  = decide && !advance && decReq;
    strobe.amount  = amt;
    strobe.level   = stage;
    strobe.carryOk = (stage == STG_FINE) && !locked;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage   <= STG_CYCLE;
      locked  <= 1'b0;
      haveDir <= 1'b0;
      lastUp  <= 1'b0;
      stepQ   <= FIELD_MID;
      hits    <= '0;
    end else if (advance) begin
      stage   <= stage_e'(stage + 2'd1);
      stepQ   <= FIELD_MID;
      haveDir <= 1'b0;
      hits    <= '0;
    end else if (decide) begin
      haveDir <= 1'b1;
      lastUp  <= incReq;
      if (!locked) begin
        stepQ <= amt;
        if (stage == STG_FINE) begin
          if (tinyRev) begin
            if (hits == HIT_W'(LOCK_HITS - 1)) begin
              locked <= 1'b1;
              hits   <= '0;
            end else begin
              hits <= hits + HIT_W'(1);
            end
          end else begin
            hits <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dcs_dpath.sv
module dcs_dpath
  import dcs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  output logic [FIELD_W-1:0] cycleField,
  output logic [FIELD_W-1:0] coarseField,
  output logic [FIELD_W-1:0] fineField
);
  localparam int FINE_IDX   = 0;
  localparam int COARSE_IDX = 1;
  localparam int CYCLE_IDX  = 2;

  logic [FIELD_W-1:0] fieldQ [NUM_FIELDS];
  logic [FIELD_W-1:0] fieldD [NUM_FIELDS];

  int                 idx;
  int                 raw;
  logic               over;
  logic               under;
  logic [FIELD_W-1:0] clamped;

  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) fieldD[i] = fieldQ[i];
    idx = CYCLE_IDX - int'(strobe.level);
    if (idx < 0) idx = FINE_IDX;
    raw = strobe.moveUp ? int'(fieldQ[idx]) + int'(strobe.amount)
                        : int'(fieldQ[idx]) - int'(strobe.amount);
    over    = raw > int'(FIELD_MAX);
    under   = raw < 0;
    clamped = over ? FIELD_MAX : (under ? '0 : FIELD_W'(raw));
    if (strobe.moveUp || strobe.moveDn) begin
      if (idx == FINE_IDX && strobe.carryOk && over && fieldQ[COARSE_IDX] != FIELD_MAX) begin
        fieldD[COARSE_IDX] = fieldQ[COARSE_IDX] + FIELD_W'(1);
        fieldD[FINE_IDX]   = FIELD_MID;
      end else if (idx == FINE_IDX && strobe.carryOk && under && fieldQ[COARSE_IDX] != '0) begin
        fieldD[COARSE_IDX] = fieldQ[COARSE_IDX] - FIELD_W'(1);
        fieldD[FINE_IDX]   = FIELD_MID;
      end else begin
        fieldD[idx] = clamped;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_FIELDS; i++)
      fieldQ[i] <= rstN ? fieldD[i] : FIELD_MID;
  end

  assign cycleField  = fieldQ[CYCLE_IDX];
  assign coarseField = fieldQ[COARSE_IDX];
  assign fineField   = fieldQ[FINE_IDX];
endmodule

// File: rtl/delay_code_search.sv
module delay_code_search
  import dcs_pkg::*;
#(
  parameter int LOCK_HITS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               incReq,
  input  logic               decReq,
  input  logic               belowStep,
  output logic [FIELD_W-1:0] cycleField,
  output logic [FIELD_W-1:0] coarseField,
  output logic [FIELD_W-1:0] fineField,
  output logic [1:0]         stage,
  output logic               locked
);
  ctrlStrobe_t strobe;
  stage_e      stageQ;

  dcs_ctrl #(.LOCK_HITS(LOCK_HITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .incReq(incReq), .decReq(decReq),
    .belowStep(belowStep), .strobe(strobe), .stage(stageQ), .locked(locked)
  );

  dcs_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cycleField(cycleField), .coarseField(coarseField), .fineField(fineField)
  );

  assign stage = stageQ;
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker (
  input logic       clk,
  input logic       rstN,
  input logic       incReq,
  input logic       decReq,
  input logic       belowStep,
  input logic [3:0] cycleField,
  input logic [3:0] coarseField,
  input logic [3:0] fineField,
  input logic [1:0] stage,
  input logic       locked
);
  AST_STAGE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    stage != 2'd3) else $error("stage code out of range"); // R2

  AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (belowStep && stage != 2'd2) |=> (stage == $past(stage) + 2'd1)) else $error("stage did not advance"); // R2

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!belowStep || stage == 2'd2) |=> $stable(stage)) else $error("stage moved without handoff"); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(incReq ^ decReq) |=> ($stable(cycleField) && $stable(coarseField) && $stable(fineField))) else $error("field moved with no decision"); // R3

  AST_CYCLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (stage == 2'd0) |=> ($stable(coarseField) && $stable(fineField))) else $error("lower field moved in cycle stage"); // R3

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked) else $error("lock dropped"); // R7

  AST_LOCK_IN_FINE: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> (stage == 2'd2)) else $error("lock outside fine stage"); // R7

  AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> ($stable(cycleField) && $stable(coarseField))) else $error("upper fields moved while locked"); // R8

  AST_LOCK_UNIT: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> ((fineField - $past(fineField) <= 4'd1) || ($past(fineField) - fineField <= 4'd1))) else $error("locked step above one"); // R8
endmodule

bind delay_code_search dcs_checker u_dcs_checker (
  .clk(clk), .rstN(rstN), .incReq(incReq), .decReq(decReq), .belowStep(belowStep),
  .cycleField(cycleField), .coarseField(coarseField), .fineField(fineField),
  .stage(stage), .locked(locked)
);

// File: tb/delay_code_search_bench.sv
`timescale 1ns/1ps
module delay_code_search_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       incReq = 1'b0;
  logic       decReq = 1'b0;
  logic       belowStep = 1'b0;
  logic [3:0] cycleField, coarseField, fineField;
  logic [1:0] stage;
  logic       locked;

  int nChecks = 0;
  int nFails = 0;

  typedef struct {
    int    c, k, f, s, l;
    string tag;
  } exp_t;
  exp_t q[$];

  int mC, mK, mF, mS, mL, mStep, mHave, mLast, mHits;

  always #10 clk = ~clk;

  delay_code_search u_delay_code_search (
    .clk(clk), .rstN(rstN), .incReq(incReq), .decReq(decReq), .belowStep(belowStep),
    .cycleField(cycleField), .coarseField(coarseField), .fineField(fineField),
    .stage(stage), .locked(locked)
  );

  function automatic void compareNow(exp_t e);
    nChecks++;
    if (cycleField != e.c[3:0] || coarseField != e.k[3:0] || fineField != e.f[3:0] ||
        stage != e.s[1:0] || locked != e.l[0]) begin
      nFails++;
      $display("FAIL %s: got c=%0d k=%0d f=%0d s=%0d l=%0d expected c=%0d k=%0d f=%0d s=%0d l=%0d",
               e.tag, cycleField, coarseField, fineField, stage, locked,
               e.c, e.k, e.f, e.s, e.l);
    end
  endfunction

  // monitor: results appear after the edge that sampled the request (R9)
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) compareNow(q.pop_front());
  end

  task automatic modelReset();
    mC = 8; mK = 8; mF = 8; mS = 0; mL = 0;
    mStep = 8; mHave = 0; mLast = 0; mHits = 0;
  endtask

  task automatic doReset();
    exp_t e;
    @(negedge clk);
    rstN = 1'b0; incReq = 0; decReq = 0; belowStep = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelReset();
    #1;
    e = '{8, 8, 8, 0, 0, "R1 reset state"};
    compareNow(e);
  endtask

  task automatic drive(input bit inc, input bit dec, input bit below, input string tag);
    int  amt, raw, cur;
    bit  up, rev, wasLocked;
    exp_t e;
    @(negedge clk);
    incReq = inc; decReq = dec; belowStep = below;
    if (below && mS != 2) begin
      mS++; mStep = 8; mHave = 0; mHits = 0;
    end else if (inc ^ dec) begin
      up = inc;
      rev = (mHave != 0) && (int'(up) != mLast);
      wasLocked = (mL != 0);
      if (wasLocked) amt = 1;
      else if (rev) amt = (mStep > 1) ? mStep / 2 : 1;
      else amt = mStep;
      cur = (mS == 0) ? mC : (mS == 1) ? mK : mF;
      raw = up ? cur + amt : cur - amt;
      if (mS == 2 && !wasLocked && raw > 15 && mK < 15) begin
        mK++; mF = 8;
      end else if (mS == 2 && !wasLocked && raw < 0 && mK > 0) begin
        mK--; mF = 8;
      end else begin
        if (raw > 15) raw = 15;
        if (raw < 0) raw = 0;
        if (mS == 0) mC = raw; else if (mS == 1) mK = raw; else mF = raw;
      end
      if (!wasLocked) begin
        if (mS == 2) begin
          if (rev && mStep == 1) begin
            mHits++;
            if (mHits == 2) begin mL = 1; mHits = 0; end
          end else mHits = 0;
        end
        mStep = amt;
      end
      mHave = 1; mLast = int'(up);
    end
    e = '{mC, mK, mF, mS, mL, tag};
    q.push_back(e);
  endtask

  task automatic flush();
    @(negedge clk);
    incReq = 0; decReq = 0; belowStep = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    modelReset();
    doReset();
    // cycle-level search: half-scale first step, saturation, reversals
    drive(1, 0, 0, "R4 R5 first step 8 saturates at 15");
    drive(0, 1, 0, "R4 reversal halves to 4");
    drive(0, 1, 0, "R4 same direction keeps 4");
    drive(1, 0, 0, "R4 reversal halves to 2");
    drive(1, 0, 0, "R3 increase active field");
    drive(1, 0, 0, "R3 increase active field");
    drive(1, 0, 0, "R5 hold at 15");
    drive(0, 1, 0, "R4 reversal step 1");
    drive(1, 1, 0, "R3 both requests no change");
    drive(0, 0, 0, "R3 no request no change");
    drive(1, 0, 1, "R2 handoff to coarse wins over request");
    // coarse search
    drive(0, 1, 0, "R4 coarse restarts at step 8");
    drive(0, 1, 0, "R5 hold at 0");
    drive(1, 0, 0, "R4 coarse reversal to 4");
    drive(0, 0, 1, "R2 handoff to fine");
    // fine search with carry and borrow
    drive(1, 0, 0, "R6 carry into coarse");
    drive(1, 0, 0, "R6 carry again");
    drive(0, 1, 0, "R4 fine reversal to 4");
    drive(0, 1, 0, "R3 fine decrease");
    drive(0, 1, 0, "R6 borrow from coarse");
    drive(0, 0, 1, "R2 belowStep ignored in fine");
    drive(1, 0, 0, "R4 reversal to 2");
    drive(0, 1, 0, "R7 reversal reaching step 1 no count");
    drive(1, 0, 0, "R7 first tiny reversal");
    drive(0, 1, 0, "R7 second tiny reversal locks");
    // locked tracking
    drive(1, 0, 0, "R8 locked +1");
    drive(0, 0, 1, "R8 belowStep ignored when locked");
    drive(0, 1, 0, "R8 locked -1");
    for (int i = 0; i < 9; i++) drive(1, 0, 0, "R8 locked climb saturates no carry");
    drive(1, 1, 0, "R8 both requests while locked");
    flush();

    // broken lock pattern: a non-reversal resets the count
    doReset();
    drive(0, 0, 1, "R2 handoff to coarse");
    drive(0, 0, 1, "R2 handoff to fine");
    drive(1, 0, 0, "R6 carry from fine");
    drive(0, 1, 0, "R4 reversal 4");
    drive(1, 0, 0, "R4 reversal 2");
    drive(0, 1, 0, "R4 reversal 1");
    drive(1, 0, 0, "R7 tiny reversal one");
    drive(1, 0, 0, "R7 same direction breaks pair");
    drive(0, 1, 0, "R7 tiny reversal restarts count");
    drive(1, 0, 0, "R7 pair complete locks");
    flush();

    // coarse at top: fine saturates instead of carrying
    doReset();
    drive(0, 0, 1, "R2 handoff to coarse");
    drive(1, 0, 0, "R5 coarse saturates 15");
    drive(0, 0, 1, "R2 handoff to fine");
    drive(1, 0, 0, "R6 no carry past full coarse");
    drive(1, 0, 0, "R6 fine holds at 15");
    flush();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule